// File: doc/BRIEF.md
# Carrier-Tracking Loop Filter and NCO

This block closes a digital carrier-recovery loop. Each clock it takes a signed phase error and scales it by two power-of-two gains chosen with 5-bit shift codes. One scaled copy is the proportional term. The other is summed into an integrator. The loop output is the proportional term plus the integrator. That output, added to a programmable 32-bit tuning word, is the per-clock increment of a 32-bit phase accumulator. The upper bits of the accumulator drive a downstream sine lookup.

The error can come from the on-chip detector, as a 16-bit signed word. It can also come from an external one-bit input, which is mapped to a fixed positive or negative full-scale step.

A small write port loads a control word and the two halves of the tuning word into shadow registers. The gain codes and the tuning word reach the loop only when their own sync strobe fires. This lets software prepare acquisition and tracking settings without disturbing the running loop. The external-select and hold bits act straight from the control register.

Top module: `carrier_nco_loop`

## Requirements
- R1: While rst is high, and on the first cycle after it is released, loop_out and phase_out are zero, because the integrator, the accumulator and all shadow and working registers are cleared.
- R2: For a working proportional code A in 1..31, the proportional term is the sign-extended 32-bit error shifted arithmetically right by A, so it rounds toward minus infinity.
- R3: A working code A of 0 makes the proportional term zero, whatever the error.
- R4: On every clock with hold clear, the integrator adds the error shifted arithmetically right by the working code B (1..31). When B is 0, it adds nothing.
- R5: A write to address 0 loads the control word. Its fields are: bits 4:0 = A, bits 9:5 = B, bit 10 = external-error select, bit 15 = hold. Bits 14:11 have no effect.
- R6: When the external-error select bit is set, the internal error is replaced. An input value of 0 is used as +32767 and a value of 1 is used as -32767.
- R7: While the hold bit is set, the integrator keeps its value. In that case loop_out changes only through the proportional term.
- R8: A written A or B code takes effect only at a clock edge where coef_sync is high. That edge copies the shadow value held before the edge.
- R9: Address 1 loads bits 15:0 of the tuning word and address 2 loads bits 31:16. The accumulator uses the new word only after a clock edge where freq_sync is high, which copies the shadow value held before that edge.
- R10: Each clock, the accumulator adds the working tuning word plus the registered loop_out, modulo 2^32. phase_out is accumulator bits 31:16.
- R11: loop_out registers the proportional term of the current error plus the integrator value held before the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 tuning low, 2 tuning high) |
| wr_data | input | 16 | Register write data |
| coef_sync | input | 1 | Commit shadow A/B codes to the loop |
| freq_sync | input | 1 | Commit shadow tuning word to the loop |
| phase_err | input | 16 | Signed internal phase error |
| ext_err | input | 1 | External one-bit error (0 advance, 1 retard) |
| loop_out | output | 32 | Registered loop filter output |
| phase_out | output | 16 | Upper bits of the phase accumulator |

## Verification
An error applied in cycle n shows on loop_out after the next rising edge. It reaches phase_out one edge later. A register write needs one edge to reach the shadow and a sync strobe needs another to reach the working set, so a change of gain or tuning word is visible one or two edges after its strobe. The bench keeps a cycle model that advances on the same rising edges from the same stimulus. It compares both outputs at every falling edge, so each result is checked in exactly the cycle it is due. The sweeps cover every A and B code against a set of error values, including both extremes and -1, and they include wrap of the accumulator.

// File: rtl/cnl_pkg.sv
package cnl_pkg;
  localparam int CODE_W   = 5;
  localparam int CTRL_W   = 16;
  localparam int A_LSB    = 0;
  localparam int B_LSB    = 5;
  localparam int EXT_BIT  = 10;
  localparam int HOLD_BIT = 15;
  localparam int ADDR_W   = 2;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_FREQ = 1;
endpackage

// File: rtl/cnl_regs.sv
module cnl_regs
  import cnl_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              coef_sync,
  input  logic              freq_sync,
  output logic [CODE_W-1:0] a_work,
  output logic [CODE_W-1:0] b_work,
  output logic              ext_sel,
  output logic              hold,
  output logic [ACC_W-1:0]  freq_work
);
  localparam int NHALF = ACC_W / HALF_W;

  logic [CODE_W-1:0] a_sh, b_sh;
  logic [ACC_W-1:0]  freq_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_sh    <= '0;
      b_sh    <= '0;
      ext_sel <= 1'b0;
      hold    <= 1'b0;
    end else if (wr_en && wr_addr == ADDR_W'(ADDR_CTRL)) begin
      a_sh    <= wr_data[A_LSB +: CODE_W];
      b_sh    <= wr_data[B_LSB +: CODE_W];
      ext_sel <= wr_data[EXT_BIT];
      hold    <= wr_data[HOLD_BIT];
    end
  end

  for (genvar i = 0; i < NHALF; i++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst)
        freq_sh[i*HALF_W +: HALF_W] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(ADDR_FREQ + i))
        freq_sh[i*HALF_W +: HALF_W] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_work    <= '0;
      b_work    <= '0;
      freq_work <= '0;
    end else begin
      if (coef_sync) begin
        a_work <= a_sh;
        b_work <= b_sh;
      end
      if (freq_sync)
        freq_work <= freq_sh;
    end
  end
endmodule

// File: rtl/cnl_scale.sv
module cnl_scale #(
  parameter int W      = 32,
  parameter int CODE_W = 5
) (
  input  logic signed [W-1:0] din,
  input  logic [CODE_W-1:0]   code,
  output logic signed [W-1:0] dout
);
  always_comb begin
    if (code == '0) dout = '0;
    else            dout = din >>> code;
  end
endmodule

// File: rtl/cnl_filter.sv
module cnl_filter
  import cnl_pkg::*;
#(
  parameter int ERR_W = 16,
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ERR_W-1:0] phase_err,
  input  logic                    ext_err,
  input  logic                    ext_sel,
  input  logic                    hold,
  input  logic [CODE_W-1:0]       a_code,
  input  logic [CODE_W-1:0]       b_code,
  output logic signed [ACC_W-1:0] prop,
  output logic signed [ACC_W-1:0] integ,
  output logic signed [ACC_W-1:0] loop_q
);
  localparam int FULL_SCALE = 2**(ERR_W-1) - 1;
  localparam logic signed [ACC_W-1:0] FS_POS = ACC_W'(FULL_SCALE);

  logic signed [ACC_W-1:0] err_ext, err_sel, int_inc;

  assign err_ext = {{(ACC_W-ERR_W){phase_err[ERR_W-1]}}, phase_err};
  assign err_sel = ext_sel ? (ext_err ? -FS_POS : FS_POS) : err_ext;

  cnl_scale #(.W(ACC_W), .CODE_W(CODE_W)) u_prop (
    .din(err_sel), .code(a_code), .dout(prop));
  cnl_scale #(.W(ACC_W), .CODE_W(CODE_W)) u_int (
    .din(err_sel), .code(b_code), .dout(int_inc));

  always_ff @(posedge clk) begin
    if (rst) begin
      integ  <= '0;
      loop_q <= '0;
    end else begin
      if (!hold) integ <= integ + int_inc;
      loop_q <= prop + integ;
    end
  end
endmodule

// File: rtl/carrier_nco_loop.sv
module carrier_nco_loop
  import cnl_pkg::*;
#(
  parameter int ERR_W  = 16,
  parameter int ACC_W  = 32,
  parameter int HALF_W = 16,
  parameter int PH_W   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [HALF_W-1:0]       wr_data,
  input  logic                    coef_sync,
  input  logic                    freq_sync,
  input  logic signed [ERR_W-1:0] phase_err,
  input  logic                    ext_err,
  output logic signed [ACC_W-1:0] loop_out,
  output logic [PH_W-1:0]         phase_out
);
  logic [CODE_W-1:0]       a_work, b_work;
  logic                    ext_sel, hold;
  logic [ACC_W-1:0]        freq_work;
  logic signed [ACC_W-1:0] prop, integ;
  logic [ACC_W-1:0]        acc;

  cnl_regs #(.ACC_W(ACC_W), .HALF_W(HALF_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .coef_sync(coef_sync), .freq_sync(freq_sync),
    .a_work(a_work), .b_work(b_work), .ext_sel(ext_sel), .hold(hold),
    .freq_work(freq_work));

  cnl_filter #(.ERR_W(ERR_W), .ACC_W(ACC_W)) u_filt (
    .clk(clk), .rst(rst), .phase_err(phase_err), .ext_err(ext_err),
    .ext_sel(ext_sel), .hold(hold), .a_code(a_work), .b_code(b_work),
    .prop(prop), .integ(integ), .loop_q(loop_out));

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc + freq_work + loop_out;
  end

  assign phase_out = acc[ACC_W-1 -: PH_W];
endmodule

// File: rtl/cnl_checker.sv
module cnl_checker #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 16,
  parameter int CW    = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             hold,
  input logic             coef_sync,
  input logic             freq_sync,
  input logic [CW-1:0]    a_code,
  input logic [CW-1:0]    b_code,
  input logic [ACC_W-1:0] prop,
  input logic [ACC_W-1:0] integ,
  input logic [ACC_W-1:0] freq_work,
  input logic [ACC_W-1:0] loop_out,
  input logic [ACC_W-1:0] acc,
  input logic [PH_W-1:0]  phase_out
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (loop_out == '0 && phase_out == '0));

  p_zero_code_r3: assert property (@(posedge clk) disable iff (rst)
    (a_code == '0) |-> (prop == '0));

  p_hold_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(integ));

  p_coef_commit_r8: assert property (@(posedge clk) disable iff (rst)
    !coef_sync |=> ($stable(a_code) && $stable(b_code)));

  p_freq_commit_r9: assert property (@(posedge clk) disable iff (rst)
    !freq_sync |=> $stable(freq_work));

  p_acc_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (freq_work == '0 && loop_out == '0) |=> $stable(acc));
endmodule

bind carrier_nco_loop cnl_checker #(.ACC_W(ACC_W), .PH_W(PH_W), .CW(cnl_pkg::CODE_W)) u_chk (
  .clk(clk), .rst(rst), .hold(hold), .coef_sync(coef_sync), .freq_sync(freq_sync),
  .a_code(a_work), .b_code(b_work), .prop(prop), .integ(integ),
  .freq_work(freq_work), .loop_out(loop_out), .acc(acc), .phase_out(phase_out));

// File: tb/tb_carrier_nco_loop.sv
module tb_carrier_nco_loop;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        coef_sync = 1'b0, freq_sync = 1'b0;
  logic signed [15:0] phase_err = '0;
  logic        ext_err = 1'b0;
  logic signed [31:0] loop_out;
  logic [15:0] phase_out;

  int vectors = 0, errors = 0;
  string tag = "R1";

  carrier_nco_loop dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .coef_sync(coef_sync), .freq_sync(freq_sync), .phase_err(phase_err),
    .ext_err(ext_err), .loop_out(loop_out), .phase_out(phase_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  // cycle model built from the requirements
  logic [15:0] m_ctrl;
  logic [4:0]  m_a, m_b;
  logic [31:0] m_fsh, m_f, m_acc;
  logic signed [31:0] m_integ, m_loop;

  function automatic logic signed [31:0] sc(input logic signed [31:0] v, input logic [4:0] c);
    if (c == 5'd0) return 32'sd0;
    return v >>> c;
  endfunction

  always @(posedge clk) begin
    logic signed [31:0] e;
    if (rst) begin
      m_ctrl <= '0; m_a <= '0; m_b <= '0; m_fsh <= '0; m_f <= '0;
      m_acc <= '0; m_integ <= '0; m_loop <= '0;
    end else begin
      e = m_ctrl[10] ? (ext_err ? -32'sd32767 : 32'sd32767) : 32'(phase_err);
      if (!m_ctrl[15]) m_integ <= m_integ + sc(e, m_b);
      m_loop <= sc(e, m_a) + m_integ;
      m_acc  <= m_acc + m_f + m_loop;
      if (coef_sync) begin m_a <= m_ctrl[4:0]; m_b <= m_ctrl[9:5]; end
      if (freq_sync) m_f <= m_fsh;
      if (wr_en) begin
        if (wr_addr == 2'd0) m_ctrl <= wr_data;
        if (wr_addr == 2'd1) m_fsh[15:0] <= wr_data;
        if (wr_addr == 2'd2) m_fsh[31:16] <= wr_data;
      end
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (loop_out !== m_loop || phase_out !== m_acc[31:16]) begin
      errors++;
      $display("FAIL %s: loop_out=%0d phase_out=%h expected loop_out=%0d phase_out=%h",
               tag, loop_out, phase_out, m_loop, m_acc[31:16]);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic csync();
    coef_sync = 1'b1; step(); coef_sync = 1'b0;
  endtask

  task automatic fsync();
    freq_sync = 1'b1; step(); freq_sync = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; step(); step(); rst = 1'b0;
  endtask

  localparam logic signed [15:0] EV [6] = '{16'sd32767, -16'sd32768, -16'sd1, 16'sd1, 16'sd12345, -16'sd777};

  initial begin
    @(negedge clk);
    // R1: reset state, including first cycle after release
    tag = "R1";
    do_reset();
    phase_err = 16'sd5000;
    step(); step();
    // R2 / R3: every A code against the error set, integrator off
    for (int a = 0; a < 32; a++) begin
      tag = (a == 0) ? "R3" : "R2";
      wr(2'd0, 16'(a));
      csync();
      for (int i = 0; i < 6; i++) begin phase_err = EV[i]; step(); end
    end
    // R8: written code ignored until sync; sync with simultaneous write takes old shadow
    tag = "R8";
    do_reset();
    wr(2'd0, 16'h0003);
    phase_err = -16'sd4096; step(); step();
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0007; coef_sync = 1'b1;
    step();
    wr_en = 1'b0; coef_sync = 1'b0;
    step(); step();
    csync(); step();
    // R4: every B code, integrator accumulates
    for (int b = 0; b < 32; b++) begin
      tag = "R4";
      do_reset();
      wr(2'd0, 16'(b << 5));
      csync();
      for (int i = 0; i < 6; i++) begin phase_err = EV[i]; step(); end
    end
    // suggested acquisition and tracking settings
    tag = "R11";
    do_reset();
    wr(2'd0, 16'h028A); csync();
    for (int i = 0; i < 12; i++) begin phase_err = EV[i % 6]; step(); end
    wr(2'd0, 16'h038E); csync();
    for (int i = 0; i < 12; i++) begin phase_err = EV[(i + 3) % 6]; step(); end
    // R7: hold freezes integrator
    tag = "R7";
    wr(2'd0, 16'h8000 | 16'h0023);
    for (int i = 0; i < 8; i++) begin phase_err = EV[i % 6]; step(); end
    wr(2'd0, 16'h0023);
    for (int i = 0; i < 4; i++) step();
    // R5: unused bits 14:11 have no effect
    tag = "R5";
    do_reset();
    wr(2'd0, 16'h7800 | 16'h0044);
    csync();
    for (int i = 0; i < 6; i++) begin phase_err = EV[i]; step(); end
    // R6: external one-bit error
    tag = "R6";
    wr(2'd0, 16'h0400 | 16'h0044);
    phase_err = 16'sd9999;
    for (int i = 0; i < 10; i++) begin ext_err = (i % 3 == 0); step(); end
    ext_err = 1'b0;
    // R9: tuning word halves held until sync
    tag = "R9";
    do_reset();
    phase_err = '0;
    wr(2'd1, 16'h1234); wr(2'd2, 16'h0400);
    step(); step();
    fsync();
    for (int i = 0; i < 8; i++) step();
    // R10: accumulator wrap with a large word plus loop term
    tag = "R10";
    wr(2'd1, 16'hFFFF); wr(2'd2, 16'hF000);
    wr(2'd0, 16'h0021); csync(); fsync();
    for (int i = 0; i < 40; i++) begin phase_err = EV[i % 6]; step(); end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule